// File: doc/BRIEF.md
# Oversampled Serial Character Receiver

This block rebuilds characters from an asynchronous serial line. A one-cycle tick at sixteen times the bit rate paces the sampling. The block looks for a falling edge and confirms the start bit half-way through it. It then samples each data bit, the optional parity bit and the stop bits at the middle of the bit. Software-facing logic sets the character format through static inputs: 5 to 8 data bits, odd, even or no parity, and one, one and a half or two stop bits.

Each completed character is written into a 16-entry receive queue together with three flags: parity error, framing error and break. The entry at the head of the queue drives the read data and the per-character flags. A one-cycle read strobe removes that entry. A sticky overrun flag records a character lost because the queue was full. With the queue disabled, the block acts as a single holding register.

Top module: `serial_rx_core`

## Requirements
- R1: `wordLen` selects the data bits per character (0=5, 1=6, 2=7, 3=8). Bits arrive least significant first and appear right-aligned on `rdData`, with the unused upper bits zero.
- R2: With `parityEn`=1, a parity bit follows the data. `parityOdd`=1 demands an odd count of ones over data and parity, and 0 demands an even count. A mismatch sets `parityErr` for that character. With `parityEn`=0, no parity bit is expected and `parityErr` stays 0.
- R3: `stopSel` selects the stop length (0=one, 1=one and a half, 2 or 3=two). Every stop sample is checked, and any stop sample at 0 sets `framingErr` for that character.
- R4: A low pulse that is no longer high... is not a start bit unless the line is still low at the eighth tick after the falling edge. A shorter pulse stores nothing, and the receiver goes back to waiting for an edge.
- R5: A line held low through the whole character, including every stop sample, stores exactly one entry. That entry has data 0, `breakFlag`=1, `framingErr`=1 and `parityErr`=0. Nothing more is stored until the line has returned high.
- R6: Entries leave in arrival order. `fillLevel` gives the count and `dataReady` is 1 whenever the count is non-zero. A pulse on `readStrobe` removes the head entry. When the queue is empty, `rdData` and the per-character flags read 0.
- R7: A character that completes while the queue is full is discarded and sets `overrun`. The stored entries are kept. `overrun` stays set until the next `readStrobe`.
- R8: With `fifoEnable`=0 the queue holds one character, and a second character raises `overrun`. Any change of `fifoEnable` empties the queue.
- R9: After reset, the queue is empty and every status output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| rxSerial | input | 1 | Asynchronous serial line, idle high |
| sampleTick | input | 1 | One-cycle pulse at 16x the bit rate |
| wordLen | input | 2 | Data bits per character (0=5 .. 3=8) |
| parityEn | input | 1 | Parity bit present and checked |
| parityOdd | input | 1 | 1 = odd parity, 0 = even parity |
| stopSel | input | 2 | Stop length: 0 one, 1 one and a half, 2/3 two |
| fifoEnable | input | 1 | 1 = 16-entry queue, 0 = single holding register |
| readStrobe | input | 1 | Removes the head entry |
| rdData | output | 8 | Head character, right-aligned |
| dataReady | output | 1 | Queue not empty |
| overrun | output | 1 | Sticky: a character was lost |
| parityErr | output | 1 | Head character failed parity |
| framingErr | output | 1 | Head character had a low stop sample |
| breakFlag | output | 1 | Head entry records a break |
| fillLevel | output | 5 | Number of stored entries |

## Verification
The format table sends characters whose bit patterns distinguish the cases that matter. Upper bits set in words shorter than 8 bits show that unused bits are masked. Mixed ones and zeros with both parity senses show whether parity is inverted or computed over the wrong bits. Each stop length appears at least once, together with a bad parity bit and a bad stop bit. Directed sequences then cover the remaining behaviour:
- a runt low pulse followed by a good character (false-start rejection and recovery);
- a long low level (exactly one break entry);
- seventeen back-to-back characters (order, overrun and keeping the stored entries);
- single-register mode, and the queue being emptied when the mode changes.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

  localparam int MAX_BITS = 8;

  localparam logic [1:0] STOP_ONE      = 2'd0;
  localparam logic [1:0] STOP_ONE_HALF = 2'd1;

  typedef enum logic [2:0] {
    ST_HUNT,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP1,
    ST_STOP2,
    ST_BRKWAIT
  } rxState_t;

  typedef struct packed {
    logic clear;
    logic shiftData;
    logic sampleParity;
    logic push;
    logic frameBad;
    logic breakSeen;
  } rxStrobes_t;

endpackage

// File: rtl/rx_ctrl.sv
module rx_ctrl
  import serial_rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sampleTick,
  input  logic       rxLine,
  input  logic       rxFall,
  input  logic [1:0] wordLen,
  input  logic       parityEn,
  input  logic [1:0] stopSel,
  output rxStrobes_t strobes
);

  localparam int CNT_W = $clog2(OSR);
  localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OSR / 2 - 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OSR - 1);
  localparam logic [CNT_W-1:0] HALF_CNT = CNT_W'((OSR * 3) / 4 - 1);

  rxState_t         state, nState;
  logic [CNT_W-1:0] tickCnt, nTick;
  logic [2:0]       bitCnt, nBit;
  logic             zeroSoFar, nZero;
  logic             stopBad, nStopBad;
  logic [2:0]       lastBit;
  logic [CNT_W-1:0] stop2Limit;

  assign lastBit    = {1'b1, wordLen};
  assign stop2Limit = (stopSel == STOP_ONE_HALF) ? HALF_CNT : LAST_CNT;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_HUNT;
      tickCnt   <= '0;
      bitCnt    <= '0;
      zeroSoFar <= 1'b0;
      stopBad   <= 1'b0;
    end else begin
      state     <= nState;
      tickCnt   <= nTick;
      bitCnt    <= nBit;
      zeroSoFar <= nZero;
      stopBad   <= nStopBad;
    end
  end

  always_comb begin
    nState   = state;
    nTick    = tickCnt;
    nBit     = bitCnt;
    nZero    = zeroSoFar;
    nStopBad = stopBad;
    strobes  = '0;
    unique case (state)
      ST_HUNT: begin
        if (rxFall) begin
          nState        = ST_START;
          nTick         = '0;
          nZero         = 1'b1;
          nStopBad      = 1'b0;
          strobes.clear = 1'b1;
        end
      end
      ST_START: begin
        if (sampleTick) begin
          if (tickCnt == MID_CNT) begin
            nTick = '0;
            nBit  = '0;
            if (rxLine) nState = ST_HUNT;
            else        nState = ST_DATA;
          end else begin
            nTick = tickCnt + 1'b1;
          end
        end
      end
      ST_DATA: begin
        if (sampleTick) begin
          if (tickCnt == LAST_CNT) begin
            strobes.shiftData = 1'b1;
            nTick = '0;
            if (rxLine) nZero = 1'b0;
            if (bitCnt == lastBit) nState = parityEn ? ST_PARITY : ST_STOP1;
            else                   nBit = bitCnt + 1'b1;
          end else begin
            nTick = tickCnt + 1'b1;
          end
        end
      end
      ST_PARITY: begin
        if (sampleTick) begin
          if (tickCnt == LAST_CNT) begin
            strobes.sampleParity = 1'b1;
            nTick  = '0;
            if (rxLine) nZero = 1'b0;
            nState = ST_STOP1;
          end else begin
            nTick = tickCnt + 1'b1;
          end
        end
      end
      ST_STOP1: begin
        if (sampleTick) begin
          if (tickCnt == LAST_CNT) begin
            nTick = '0;
            if (stopSel == STOP_ONE) begin
              strobes.push      = 1'b1;
              strobes.frameBad  = !rxLine;
              strobes.breakSeen = zeroSoFar && !rxLine;
              nState = (zeroSoFar && !rxLine) ? ST_BRKWAIT : ST_HUNT;
            end else begin
              nStopBad = !rxLine;
              if (rxLine) nZero = 1'b0;
              nState = ST_STOP2;
            end
          end else begin
            nTick = tickCnt + 1'b1;
          end
        end
      end
      ST_STOP2: begin
        if (sampleTick) begin
          if (tickCnt == stop2Limit) begin
            nTick             = '0;
            strobes.push      = 1'b1;
            strobes.frameBad  = stopBad || !rxLine;
            strobes.breakSeen = zeroSoFar && !rxLine;
            nState = (zeroSoFar && !rxLine) ? ST_BRKWAIT : ST_HUNT;
          end else begin
            nTick = tickCnt + 1'b1;
          end
        end
      end
      ST_BRKWAIT: begin
        if (rxLine) nState = ST_HUNT;
      end
      default: nState = ST_HUNT;
    endcase
  end

endmodule

// File: rtl/rx_datapath.sv
module rx_datapath
  import serial_rx_pkg::*;
#(
  parameter int DEPTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         rxSerial,
  input  rxStrobes_t                   strobes,
  input  logic [1:0]                   wordLen,
  input  logic                         parityEn,
  input  logic                         parityOdd,
  input  logic                         fifoEnable,
  input  logic                         readStrobe,
  output logic                         rxLine,
  output logic                         rxFall,
  output logic [MAX_BITS-1:0]          rdData,
  output logic                         dataReady,
  output logic                         overrun,
  output logic                         parityErr,
  output logic                         framingErr,
  output logic                         breakFlag,
  output logic [$clog2(DEPTH+1)-1:0]   fillLevel
);

  localparam int PTR_W   = $clog2(DEPTH);
  localparam int CNT_W   = $clog2(DEPTH + 1);
  localparam int ENTRY_W = MAX_BITS + 3;

  // input synchronizer, one flop per stage
  logic [SYNC_STAGES-1:0] syncReg;
  logic                   rxPrev;

  genvar s;
  generate
    for (s = 0; s < SYNC_STAGES; s++) begin : gSync
      if (s == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncReg[0] <= 1'b1;
          else       syncReg[0] <= rxSerial;
        end
      end else begin : gNext
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncReg[s] <= 1'b1;
          else       syncReg[s] <= syncReg[s-1];
        end
      end
    end
  endgenerate

  assign rxLine = syncReg[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rxPrev <= 1'b1;
    else       rxPrev <= rxLine;
  end

  assign rxFall = rxPrev && !rxLine;

  // character assembly
  logic [MAX_BITS-1:0] shiftReg;
  logic                parAcc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      parAcc   <= 1'b0;
    end else if (strobes.clear) begin
      shiftReg <= '0;
      parAcc   <= 1'b0;
    end else if (strobes.shiftData) begin
      shiftReg <= {rxLine, shiftReg[MAX_BITS-1:1]};
      parAcc   <= parAcc ^ rxLine;
    end else if (strobes.sampleParity) begin
      parAcc   <= parAcc ^ rxLine;
    end
  end

  logic [MAX_BITS-1:0] alignedChar;
  logic                charParBad;
  logic [ENTRY_W-1:0]  newEntry;

  assign alignedChar = shiftReg >> (2'd3 - wordLen);
  assign charParBad  = parityEn && (parAcc ^ parityOdd) && !strobes.breakSeen;
  assign newEntry    = {strobes.breakSeen, strobes.frameBad || strobes.breakSeen,
                        charParBad, strobes.breakSeen ? '0 : alignedChar};

  // receive queue
  logic [ENTRY_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]   wrPtr, rdPtr;
  logic [CNT_W-1:0]   count, capacity;
  logic               fifoEnPrev, flush, pop, room, pushOk, lostChar;

  assign capacity = fifoEnable ? CNT_W'(DEPTH) : CNT_W'(1);
  assign flush    = fifoEnable ^ fifoEnPrev;
  assign pop      = readStrobe && (count != '0) && !flush;
  assign room     = (count < capacity) || pop;
  assign pushOk   = strobes.push && !flush && room;
  assign lostChar = strobes.push && !flush && !room;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (pushOk) mem[wrPtr] <= newEntry;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr      <= '0;
      rdPtr      <= '0;
      count      <= '0;
      fifoEnPrev <= 1'b0;
      overrun    <= 1'b0;
    end else begin
      fifoEnPrev <= fifoEnable;
      if (flush) begin
        wrPtr <= '0;
        rdPtr <= '0;
        count <= '0;
      end else begin
        if (pushOk) wrPtr <= bump(wrPtr);
        if (pop)    rdPtr <= bump(rdPtr);
        count <= count + CNT_W'(pushOk) - CNT_W'(pop);
      end
      if (lostChar)        overrun <= 1'b1;
      else if (readStrobe) overrun <= 1'b0;
    end
  end

  logic [ENTRY_W-1:0] headEntry;
  assign headEntry  = (count != '0) ? mem[rdPtr] : '0;
  assign rdData     = headEntry[MAX_BITS-1:0];
  assign parityErr  = headEntry[MAX_BITS];
  assign framingErr = headEntry[MAX_BITS+1];
  assign breakFlag  = headEntry[MAX_BITS+2];
  assign dataReady  = (count != '0);
  assign fillLevel  = count;

endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
  import serial_rx_pkg::*;
#(
  parameter int DEPTH       = 16,
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       rxSerial,
  input  logic                       sampleTick,
  input  logic [1:0]                 wordLen,
  input  logic                       parityEn,
  input  logic                       parityOdd,
  input  logic [1:0]                 stopSel,
  input  logic                       fifoEnable,
  input  logic                       readStrobe,
  output logic [7:0]                 rdData,
  output logic                       dataReady,
  output logic                       overrun,
  output logic                       parityErr,
  output logic                       framingErr,
  output logic                       breakFlag,
  output logic [$clog2(DEPTH+1)-1:0] fillLevel
);

  rxStrobes_t strobes;
  logic       rxLine, rxFall;

  rx_ctrl #(.OSR(OSR)) uCtrl (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .rxLine(rxLine),
    .rxFall(rxFall), .wordLen(wordLen), .parityEn(parityEn),
    .stopSel(stopSel), .strobes(strobes)
  );

  rx_datapath #(.DEPTH(DEPTH), .SYNC_STAGES(SYNC_STAGES)) uPath (
    .clk(clk), .rstN(rstN), .rxSerial(rxSerial), .strobes(strobes),
    .wordLen(wordLen), .parityEn(parityEn), .parityOdd(parityOdd),
    .fifoEnable(fifoEnable), .readStrobe(readStrobe), .rxLine(rxLine),
    .rxFall(rxFall), .rdData(rdData), .dataReady(dataReady),
    .overrun(overrun), .parityErr(parityErr), .framingErr(framingErr),
    .breakFlag(breakFlag), .fillLevel(fillLevel)
  );

endmodule

// File: rtl/serial_rx_checker.sv
module serial_rx_checker #(
  parameter int DEPTH = 16
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       fifoEnable,
  input logic                       overrun,
  input logic                       breakFlag,
  input logic                       framingErr,
  input logic                       parityErr,
  input logic [7:0]                 rdData,
  input logic [$clog2(DEPTH+1)-1:0] fillLevel
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  // R5: a break entry carries zero data, framing set, parity clear
  assert_break_entry_R5: assert property (@(posedge clk) disable iff (!rstN)
    breakFlag |-> (framingErr && !parityErr && rdData == 8'h00));

  // R6: an empty queue presents zero data and clear flags
  assert_empty_head_R6: assert property (@(posedge clk) disable iff (!rstN)
    (fillLevel == '0) |-> (rdData == 8'h00 && !breakFlag && !framingErr && !parityErr));

  // R6: the fill count grows by at most one per cycle
  assert_fill_step_R6: assert property (@(posedge clk) disable iff (!rstN)
    (fillLevel > $past(fillLevel)) |-> (fillLevel == $past(fillLevel) + CNT_W'(1)));

  // R7: a lost character leaves the stored count untouched
  assert_overrun_keeps_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> $stable(fillLevel));

  // R8: in single-register mode at most one entry is held
  assert_single_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!fifoEnable && !$past(fifoEnable)) |-> (fillLevel <= CNT_W'(1)));

endmodule

bind serial_rx_core serial_rx_checker #(.DEPTH(DEPTH)) uChk (
  .clk(clk), .rstN(rstN), .fifoEnable(fifoEnable), .overrun(overrun),
  .breakFlag(breakFlag), .framingErr(framingErr), .parityErr(parityErr),
  .rdData(rdData), .fillLevel(fillLevel)
);

// File: tb/tb_serial_rx_core.sv
module tb_serial_rx_core;

  localparam int CLKS_PER_TICK = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxSerial = 1'b1;
  logic       sampleTick = 1'b0;
  logic [1:0] wordLen = 2'd3;
  logic       parityEn = 1'b0;
  logic       parityOdd = 1'b0;
  logic [1:0] stopSel = 2'd0;
  logic       fifoEnable = 1'b1;
  logic       readStrobe = 1'b0;
  logic [7:0] rdData;
  logic       dataReady, overrun, parityErr, framingErr, breakFlag;
  logic [4:0] fillLevel;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  serial_rx_core dut (
    .clk(clk), .rstN(rstN), .rxSerial(rxSerial), .sampleTick(sampleTick),
    .wordLen(wordLen), .parityEn(parityEn), .parityOdd(parityOdd),
    .stopSel(stopSel), .fifoEnable(fifoEnable), .readStrobe(readStrobe),
    .rdData(rdData), .dataReady(dataReady), .overrun(overrun),
    .parityErr(parityErr), .framingErr(framingErr), .breakFlag(breakFlag),
    .fillLevel(fillLevel)
  );

  always #5 clk = ~clk;

  initial begin
    forever begin
      repeat (CLKS_PER_TICK - 1) @(negedge clk);
      sampleTick = 1'b1;
      @(negedge clk);
      sampleTick = 1'b0;
    end
  end

  typedef struct packed {
    logic [7:0] data;
    logic [1:0] len;
    logic       pEn;
    logic       pOdd;
    logic [1:0] stop;
    logic       badPar;
    logic       badStop;
    logic [7:0] expData;
    logic       expPe;
    logic       expFe;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{8'hA5, 2'd3, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 8'hA5, 1'b0, 1'b0},
    '{8'h3C, 2'd3, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 8'h3C, 1'b0, 1'b0},
    '{8'h3D, 2'd3, 1'b1, 1'b1, 2'd2, 1'b0, 1'b0, 8'h3D, 1'b0, 1'b0},
    '{8'hFF, 2'd0, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0, 8'h1F, 1'b0, 1'b0},
    '{8'hEA, 2'd1, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 8'h2A, 1'b0, 1'b0},
    '{8'hD5, 2'd2, 1'b1, 1'b1, 2'd2, 1'b0, 1'b0, 8'h55, 1'b0, 1'b0},
    '{8'h81, 2'd3, 1'b1, 1'b0, 2'd0, 1'b1, 1'b0, 8'h81, 1'b1, 1'b0},
    '{8'h12, 2'd3, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1, 8'h12, 1'b0, 1'b1},
    '{8'h0F, 2'd2, 1'b1, 1'b1, 2'd1, 1'b0, 1'b1, 8'h0F, 1'b0, 1'b1},
    '{8'h7E, 2'd0, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 8'h1E, 1'b0, 1'b0}
  };

  task automatic check(input string req, input string what,
                       input logic [15:0] actual, input logic [15:0] expected);
    testsRun++;
    if (actual !== expected) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, actual, expected);
    end
  endtask

  task automatic driveBit(input logic b, input int ticks);
    rxSerial = b;
    repeat (ticks * CLKS_PER_TICK) @(negedge clk);
  endtask

  task automatic sendFrame(input logic [7:0] d, input logic [1:0] len,
                           input logic pEn, input logic pOdd, input logic [1:0] stop,
                           input logic badPar, input logic badStop);
    logic [7:0] mask;
    logic       par;
    int         stopTicks;
    wordLen   = len;
    parityEn  = pEn;
    parityOdd = pOdd;
    stopSel   = stop;
    mask      = 8'hFF >> (3 - len);
    par       = (^(d & mask)) ^ pOdd ^ badPar;
    stopTicks = (stop == 2'd0) ? 16 : (stop == 2'd1) ? 24 : 32;
    driveBit(1'b1, 2);
    driveBit(1'b0, 16);
    for (int b = 0; b < int'(len) + 5; b++) driveBit(d[b], 16);
    if (pEn) driveBit(par, 16);
    driveBit(!badStop, stopTicks);
    driveBit(1'b1, 4);
  endtask

  task automatic readPulse();
    @(negedge clk);
    readStrobe = 1'b1;
    @(negedge clk);
    readStrobe = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R9: reset state
    check("R9", "fill", 16'(fillLevel), 16'd0);
    check("R9", "flags", {11'd0, dataReady, overrun, parityErr, framingErr, breakFlag}, 16'd0);
    check("R9", "data", 16'(rdData), 16'd0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);

    // format table: R1 length, R2 parity, R3 stop bits
    for (int i = 0; i < NVEC; i++) begin
      sendFrame(VECS[i].data, VECS[i].len, VECS[i].pEn, VECS[i].pOdd,
                VECS[i].stop, VECS[i].badPar, VECS[i].badStop);
      check("R6", "fill after frame", 16'(fillLevel), 16'd1);
      check("R1", "data", 16'(rdData), 16'(VECS[i].expData));
      check("R2", "parity flag", 16'(parityErr), 16'(VECS[i].expPe));
      check("R3", "framing flag", 16'(framingErr), 16'(VECS[i].expFe));
      check("R5", "no break", 16'(breakFlag), 16'd0);
      readPulse();
      check("R6", "fill after read", 16'(fillLevel), 16'd0);
    end

    // R4: runt low pulse rejected, then a good frame received
    wordLen = 2'd3; parityEn = 1'b0; stopSel = 2'd0;
    driveBit(1'b0, 4);
    driveBit(1'b1, 40);
    check("R4", "runt stored nothing", 16'(fillLevel), 16'd0);
    sendFrame(8'h6B, 2'd3, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0);
    check("R4", "frame after runt", 16'(rdData), 16'h6B);
    check("R4", "fill after runt", 16'(fillLevel), 16'd1);
    readPulse();

    // R5: long low level gives exactly one break entry
    driveBit(1'b0, 400);
    driveBit(1'b1, 40);
    check("R5", "break fill", 16'(fillLevel), 16'd1);
    check("R5", "break flag", 16'(breakFlag), 16'd1);
    check("R5", "break framing", 16'(framingErr), 16'd1);
    check("R5", "break data", 16'(rdData), 16'd0);
    readPulse();
    check("R5", "single entry", 16'(fillLevel), 16'd0);

    // R6/R7: fill the queue, then overflow it
    for (int i = 0; i < 16; i++)
      sendFrame(8'(i * 7 + 1), 2'd3, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0);
    check("R6", "full fill", 16'(fillLevel), 16'd16);
    check("R7", "no overrun yet", 16'(overrun), 16'd0);
    sendFrame(8'hEE, 2'd3, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0);
    check("R7", "overrun set", 16'(overrun), 16'd1);
    check("R7", "fill kept", 16'(fillLevel), 16'd16);
    for (int i = 0; i < 16; i++) begin
      check("R6", "order", 16'(rdData), 16'(8'(i * 7 + 1)));
      readPulse();
      if (i == 0) check("R7", "overrun cleared by read", 16'(overrun), 16'd0);
    end
    check("R6", "drained", 16'(dataReady), 16'd0);

    // R8: single holding register
    fifoEnable = 1'b0;
    repeat (4) @(negedge clk);
    sendFrame(8'h41, 2'd3, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0);
    sendFrame(8'h42, 2'd3, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0);
    check("R8", "one held", 16'(fillLevel), 16'd1);
    check("R8", "first kept", 16'(rdData), 16'h41);
    check("R8", "overrun in single mode", 16'(overrun), 16'd1);
    readPulse();
    check("R8", "emptied", 16'(fillLevel), 16'd0);

    // R8: mode change empties the queue
    fifoEnable = 1'b1;
    repeat (4) @(negedge clk);
    sendFrame(8'h33, 2'd3, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0);
    sendFrame(8'h34, 2'd3, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0);
    check("R8", "two stored", 16'(fillLevel), 16'd2);
    fifoEnable = 1'b0;
    repeat (3) @(negedge clk);
    check("R8", "flushed fill", 16'(fillLevel), 16'd0);
    check("R8", "flushed ready", 16'(dataReady), 16'd0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule